// File: doc/BRIEF.md
# 32-bit Integer Arithmetic and Logic Unit

This block is the purely combinational execute-stage ALU of a small RISC pipeline. It takes two operand words and a 4-bit operation code, and it drives one result word. The operations are wrap-around add and subtract, three bitwise logic functions, signed and unsigned less-than compares, three shifts, and a pass-through of the second operand. Every code without an assigned operation gives a result of zero.

The result depends only on the present inputs. It holds no state, so a pipeline puts its own registers on either side of it. The carry chain is shared by add, subtract and both compares. One right-shifting network serves all three shifts: a left shift is done by reversing the bits on the way in and on the way out. The block does not produce carry, overflow or zero flags.

Top module: `alu_core`

## Requirements
- R1: Code 0 gives opnd_a + opnd_b, truncated to 32 bits.
- R2: Code 1 gives opnd_a − opnd_b, truncated to 32 bits.
- R3: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands.
- R4: Code 5 gives 1 in bit 0 when opnd_a < opnd_b as two's-complement numbers, and 0 otherwise. Bits 31:1 are zero.
- R5: Code 6 gives 1 in bit 0 when opnd_a < opnd_b as unsigned numbers, and 0 otherwise. Bits 31:1 are zero.
- R6: Code 7 shifts opnd_a left and fills with zeros. The shift amount is opnd_b[4:0]; opnd_b[31:5] has no effect.
- R7: Code 9 shifts opnd_a right by opnd_b[4:0] and fills with zeros.
- R8: Code 8 shifts opnd_a right by opnd_b[4:0] and fills with copies of opnd_a[31].
- R9: Code 10 gives opnd_b unchanged.
- R10: Codes 11 to 15 give a result of zero.
- R11: The result follows any change of the inputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand; its low 5 bits give the shift amount |
| op_sel | input | 4 | Operation code |
| res | output | 32 | Result word |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the inputs and res. The bench changes the operands and the code just after a rising clock edge. It reads res at the following falling edge, half a period later, when the inputs have been steady for that whole time. Random pairs are run for each operation, and directed cases cover shift amounts 0 and 31, the most negative value, all-ones words, and equal operands in both compares.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32,
  parameter int OPW   = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OPW-1:0]   op_sel,
  output logic [WIDTH-1:0] res
);
  localparam int SHW = $clog2(WIDTH);

  localparam logic [OPW-1:0] OP_ADD  = OPW'(0);
  localparam logic [OPW-1:0] OP_SUB  = OPW'(1);
  localparam logic [OPW-1:0] OP_AND  = OPW'(2);
  localparam logic [OPW-1:0] OP_OR   = OPW'(3);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(4);
  localparam logic [OPW-1:0] OP_SLT  = OPW'(5);
  localparam logic [OPW-1:0] OP_SLTU = OPW'(6);
  localparam logic [OPW-1:0] OP_SLL  = OPW'(7);
  localparam logic [OPW-1:0] OP_SRA  = OPW'(8);
  localparam logic [OPW-1:0] OP_SRL  = OPW'(9);
  localparam logic [OPW-1:0] OP_CPB  = OPW'(10);

  logic             sub_mode;
  logic [WIDTH:0]   sum_w;
  logic             lt_u, lt_s;
  logic [SHW-1:0]   shamt;
  logic             go_left, fill;
  logic [WIDTH-1:0] sh_src, sh_right, sh_left;
  logic [WIDTH-1:0] stg [0:SHW];

  assign sub_mode = (op_sel == OP_SUB) || (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign sum_w = {1'b0, opnd_a} + {1'b0, opnd_b ^ {WIDTH{sub_mode}}}
               + {{WIDTH{1'b0}}, sub_mode};
  assign lt_u = ~sum_w[WIDTH];
  assign lt_s = (opnd_a[WIDTH-1] ^ opnd_b[WIDTH-1]) ? opnd_a[WIDTH-1] : sum_w[WIDTH-1];

  assign shamt   = opnd_b[SHW-1:0];
  assign go_left = (op_sel == OP_SLL);
  assign fill    = (op_sel == OP_SRA) & opnd_a[WIDTH-1];

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_rev
      assign sh_src[gi]  = go_left ? opnd_a[WIDTH-1-gi] : opnd_a[gi];
      assign sh_left[gi] = sh_right[WIDTH-1-gi];
    end
  endgenerate

  assign stg[0] = sh_src;

  generate
    for (gi = 0; gi < SHW; gi++) begin : g_stage
      localparam int D = 1 << gi;
      assign stg[gi+1] = shamt[gi] ? {{D{fill}}, stg[gi][WIDTH-1:D]} : stg[gi];
    end
  endgenerate

  assign sh_right = stg[SHW];

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: res = sum_w[WIDTH-1:0];
      OP_AND:         res = opnd_a & opnd_b;
      OP_OR:          res = opnd_a | opnd_b;
      OP_XOR:         res = opnd_a ^ opnd_b;
      OP_SLT:         res = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU:        res = {{(WIDTH-1){1'b0}}, lt_u};
      OP_SLL:         res = sh_left;
      OP_SRA, OP_SRL: res = sh_right;
      OP_CPB:         res = opnd_b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32,
  parameter int OPW   = 4
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [OPW-1:0]   op_sel,
  input logic [WIDTH-1:0] res
);
  localparam int SHW = $clog2(WIDTH);

  always_comb begin
    if (op_sel == OPW'(0))
      AST_ADD_INVERSE: assert (res - opnd_b == opnd_a) else $error("add inverse"); // R1
    if (op_sel == OPW'(1))
      AST_SUB_INVERSE: assert (res + opnd_b == opnd_a) else $error("sub inverse"); // R2
    if (op_sel == OPW'(4))
      AST_XOR_INVERSE: assert ((res ^ opnd_b) == opnd_a) else $error("xor inverse"); // R3
    if (op_sel == OPW'(5))
      AST_SLT_UPPER: assert (res[WIDTH-1:1] == '0) else $error("slt upper"); // R4
    if (op_sel == OPW'(6))
      AST_SLTU_UPPER: assert (res[WIDTH-1:1] == '0) else $error("sltu upper"); // R5
    if (op_sel == OPW'(7) && opnd_b[SHW-1:0] == '0)
      AST_SLL_NOSHIFT: assert (res == opnd_a) else $error("sll zero amount"); // R6
    if (op_sel == OPW'(8))
      AST_SRA_SIGN: assert (res[WIDTH-1] == opnd_a[WIDTH-1]) else $error("sra sign"); // R8
    if (op_sel > OPW'(10))
      AST_UNDEF_ZERO: assert (res == '0) else $error("undefined code"); // R10
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .OPW(OPW)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .res(res)
);

// File: tb/alu_core_test.sv
module alu_core_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  op = 4'd15;
  logic [31:0] y;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  alu_core uut (.opnd_a(a), .opnd_b(b), .op_sel(op), .res(y));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] x, input logic [31:0] z);
    case (c)
      4'd0:  return x + z;
      4'd1:  return x - z;
      4'd2:  return x & z;
      4'd3:  return x | z;
      4'd4:  return x ^ z;
      4'd5:  return ($signed(x) < $signed(z)) ? 32'd1 : 32'd0;
      4'd6:  return (x < z) ? 32'd1 : 32'd0;
      4'd7:  return x << z[4:0];
      4'd8:  return 32'($signed(x) >>> z[4:0]);
      4'd9:  return x >> z[4:0];
      4'd10: return z;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'd0: return "R1";  4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";  4'd6: return "R5";
      4'd7: return "R6";  4'd8: return "R8";
      4'd9: return "R7";  4'd10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] c, input logic [31:0] x, input logic [31:0] z, input string req);
    logic [31:0] exp;
    @(posedge clk);
    #1;
    op = c; a = x; b = z;
    exp = model(c, x, z);
    @(negedge clk);
    total++;
    if (y !== exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, c, x, z, y, exp);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    total++;
    if (y !== 32'd0) begin
      bad++;
      $display("FAIL R10 idle actual=%h expected=%h", y, 32'd0);
    end
  endtask

  task automatic t_random;
    for (int c = 0; c <= 10; c++)
      for (int n = 0; n < 100; n++)
        apply(4'(c), $urandom, $urandom, tag(4'(c)));
  endtask

  task automatic t_shift_edges;
    for (int c = 7; c <= 9; c++) begin
      apply(4'(c), 32'h8000_0001, 32'd0,  tag(4'(c)));
      apply(4'(c), 32'h8000_0001, 32'd31, tag(4'(c)));
      apply(4'(c), 32'hFFFF_FFFF, 32'd31, tag(4'(c)));
      apply(4'(c), 32'hC3A5_5A3C, 32'hFFFF_FFE3, tag(4'(c)));
    end
    apply(4'd7, 32'h0000_0001, 32'h0000_0020, "R6");
  endtask

  task automatic t_compare_edges;
    apply(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
    apply(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, "R4");
    apply(4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    apply(4'd5, 32'hFFFF_FFFF, 32'h0000_0000, "R4");
    apply(4'd6, 32'hFFFF_FFFF, 32'h0000_0000, "R5");
    apply(4'd6, 32'h0000_0000, 32'hFFFF_FFFF, "R5");
    apply(4'd6, 32'h8000_0000, 32'h8000_0000, "R5");
    apply(4'd6, 32'h7FFF_FFFF, 32'h8000_0000, "R5");
  endtask

  task automatic t_arith_edges;
    apply(4'd0, 32'hFFFF_FFFF, 32'd1, "R1");
    apply(4'd0, 32'h8000_0000, 32'h8000_0000, "R1");
    apply(4'd1, 32'd0, 32'd1, "R2");
    apply(4'd1, 32'h8000_0000, 32'd1, "R2");
    apply(4'd2, 32'hFFFF_FFFF, 32'h8000_0000, "R3");
    apply(4'd3, 32'h0000_0000, 32'hFFFF_FFFF, "R3");
    apply(4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    apply(4'd10, 32'h1234_5678, 32'hFFFF_FFFF, "R9");
  endtask

  task automatic t_undefined;
    for (int c = 11; c <= 15; c++)
      apply(4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
  endtask

  task automatic t_no_clock;
    #1;
    op = 4'd0; a = 32'd5; b = 32'd7;
    #1;
    total++;
    if (y !== 32'd12) begin
      bad++;
      $display("FAIL R11 actual=%h expected=%h", y, 32'd12);
    end
    a = 32'd100;
    #1;
    total++;
    if (y !== 32'd107) begin
      bad++;
      $display("FAIL R11 actual=%h expected=%h", y, 32'd107);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_random();
    t_shift_edges();
    t_compare_edges();
    t_arith_edges();
    t_undefined();
    @(negedge clk);
    t_no_clock();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule